// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block turns three asynchronous conditions into one clean, stretched system reset. A digital power-good level from an external comparator, a watchdog kick line that must see regular falling edges, and a sensed low-active reset pin are each synchronized. Any of the three can start a reset pulse. The pulse is driven on a pair of complementary outputs, one active high and one active low. A memory write-lockout flag is raised for exactly as long as reset is asserted.

All timing is set by parameters counted in clock cycles, so a design can use real timeouts while a test uses short ones. Supply-fail dips shorter than a programmable number of cycles are rejected. Every reset, whatever started it, is held for a fixed hold time that counts from the last cycle the request was present. The watchdog counter is held at zero while reset is asserted. If nobody services it after a watchdog reset ends, it expires again and produces another pulse, so pulses repeat.

Parameters are `GLITCH_CYC` (G), `WDOG_CYC` (W) and `HOLD_CYC` (H). A "cycle" is one period of `clk_i`. All inputs pass through a two-stage synchronizer.

Top module: `rstsup_top`

## Requirements
- R1: While `rst_n_i` is low, `rst_o`=1, `rst_n_o`=0 and `wr_lock_o`=1. After `rst_n_i` is released, the outputs stay asserted through H+1 rising edges and drop at the (H+2)-th.
- R2: `rst_n_o` is always the inverse of `rst_o`.
- R3: `wr_lock_o` equals `rst_o` in every cycle.
- R4: A high-to-low transition of `wdog_kick_n_i` clears the watchdog count. Kicks that come less than W cycles apart never cause a reset.
- R5: A steady level on `wdog_kick_n_i`, whether high or low, does not clear the count. After a reset is released with no kick, `rst_o` stays low for exactly W+1 cycles and then rises.
- R6: While the watchdog stays unserviced, watchdog pulses repeat. Each pulse lasts H cycles and is followed by W+1 low cycles.
- R7: Every reset pulse ends exactly H cycles after the last cycle in which a request was seen after synchronization.
- R8: Holding `ext_rst_n_i` low for L cycles, with L at least 1, raises `rst_o` on the 3rd rising edge after the first low cycle. The pulse then lasts L+H-1 cycles.
- R9: A low on `pwr_good_i` lasting D cycles gives a pulse of D+H-G cycles when D is at least G. It gives no pulse when D is less than G.
- R10: The watchdog count is held at zero while reset is asserted. Its full W-cycle period starts at release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset of the logic; its release is synchronized |
| pwr_good_i | input | 1 | Supply-good level from the comparator, 1 = supply above trip |
| wdog_kick_n_i | input | 1 | Watchdog service line; a falling edge clears the count |
| ext_rst_n_i | input | 1 | Sensed reset pin; 0 requests reset |
| rst_o | output | 1 | Reset, active high |
| rst_n_o | output | 1 | Reset, active low |
| wr_lock_o | output | 1 | Memory write lockout, 1 while reset is asserted |

## Verification
Three timing rules set when each result is due. An external request shows on `rst_o` at the third rising edge, after two synchronizer flops and the stretch register. A supply dip takes G further edges to pass the filter. A missing kick produces a rise W+1 edges after release. The bench drives inputs on falling edges and samples on falling edges. A monitor measures each pulse from rise to fall and compares its length with the next expected length in a queue; the driver queues those lengths as D+H-G, L+H-1 or H. Start and gap checks count falling-edge samples from a known reference: the release of `rst_n_i`, the first low input cycle, or the first low sample after a pulse.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;

  // Positions of the asynchronous inputs inside the shared synchronizer.
  localparam int unsigned ASYNC_W  = 3;
  localparam int unsigned BIT_PWR  = 0;
  localparam int unsigned BIT_KICK = 1;
  localparam int unsigned BIT_EXT  = 2;

  // Inactive levels: supply good, kick line high, reset pin released.
  localparam logic [ASYNC_W-1:0] ASYNC_IDLE = 3'b111;

endpackage

// File: rtl/rstsup_sync.sv
module rstsup_sync #(
  parameter int unsigned      WIDTH   = 1,
  parameter int unsigned      STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             arst_n_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/rstsup_glitch.sv
module rstsup_glitch #(
  parameter int unsigned GLITCH_CYC = 4
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic fail_i,
  output logic fail_o
);

  generate
    if (GLITCH_CYC <= 1) begin : g_pass
      logic fail_q;
      always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) fail_q <= 1'b0;
        else           fail_q <= fail_i;
      end
      assign fail_o = fail_q;
    end else begin : g_filt
      localparam int unsigned CW = $clog2(GLITCH_CYC);
      localparam logic [CW-1:0] RUN_LAST = CW'(GLITCH_CYC - 1);

      logic [CW-1:0] run_q, run_d;
      logic          fail_q, fail_d;

      // Count consecutive fail samples; declare failure on the G-th one.
      always_comb begin
        run_d  = run_q;
        fail_d = fail_q;
        if (!fail_i) begin
          run_d  = '0;
          fail_d = 1'b0;
        end else if (run_q == RUN_LAST) begin
          fail_d = 1'b1;
        end else begin
          run_d = run_q + 1'b1;
        end
      end

      always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) begin
          run_q  <= '0;
          fail_q <= 1'b0;
        end else begin
          run_q  <= run_d;
          fail_q <= fail_d;
        end
      end

      assign fail_o = fail_q;
    end
  endgenerate

endmodule

// File: rtl/rstsup_wdog.sv
module rstsup_wdog #(
  parameter int unsigned WDOG_CYC = 64
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic hold_i,
  input  logic kick_n_i,
  output logic bite_o
);

  localparam int unsigned   CW       = $clog2(WDOG_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(WDOG_CYC - 1);

  logic          kick_q;
  logic          kick_fall;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          bite_q, bite_d;

  assign kick_fall = kick_q & ~kick_n_i;

  always_comb begin
    cnt_d  = cnt_q;
    bite_d = 1'b0;
    if (hold_i || kick_fall) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_d  = '0;
      bite_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      kick_q <= 1'b1;
      cnt_q  <= '0;
      bite_q <= 1'b0;
    end else begin
      kick_q <= kick_n_i;
      cnt_q  <= cnt_d;
      bite_q <= bite_d;
    end
  end

  assign bite_o = bite_q;

endmodule

// File: rtl/rstsup_stretch.sv
module rstsup_stretch #(
  parameter int unsigned HOLD_CYC = 16
) (
  input  logic clk_i,
  input  logic arst_n_i,
  input  logic req_i,
  output logic active_o
);

  localparam int unsigned   CW       = $clog2(HOLD_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(HOLD_CYC - 1);

  logic          active_q, active_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = req_i | active_q;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (req_i) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (cnt_q == CNT_LAST) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (cnt_en) begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  assign active_o = active_q;

endmodule

// File: rtl/rstsup_top.sv
module rstsup_top
  import rstsup_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned GLITCH_CYC  = 4,
  parameter int unsigned WDOG_CYC    = 64,
  parameter int unsigned HOLD_CYC    = 16
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic pwr_good_i,
  input  logic wdog_kick_n_i,
  input  logic ext_rst_n_i,
  output logic rst_o,
  output logic rst_n_o,
  output logic wr_lock_o
);

  logic               rst_int_n;
  logic [ASYNC_W-1:0] async_raw;
  logic [ASYNC_W-1:0] async_s;
  logic               ext_sn;
  logic               fail_flt;
  logic               wd_bite;
  logic               req;
  logic               rst_active;

  // Asynchronous assertion, synchronous release of the internal reset.
  rstsup_sync #(
    .WIDTH  (1),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b0)
  ) u_rst_sync (
    .clk_i   (clk_i),
    .arst_n_i(rst_n_i),
    .d_i     (1'b1),
    .q_o     (rst_int_n)
  );

  assign async_raw[BIT_PWR]  = pwr_good_i;
  assign async_raw[BIT_KICK] = wdog_kick_n_i;
  assign async_raw[BIT_EXT]  = ext_rst_n_i;

  rstsup_sync #(
    .WIDTH  (ASYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(ASYNC_IDLE)
  ) u_in_sync (
    .clk_i   (clk_i),
    .arst_n_i(rst_int_n),
    .d_i     (async_raw),
    .q_o     (async_s)
  );

  assign ext_sn = async_s[BIT_EXT];

  rstsup_glitch #(
    .GLITCH_CYC(GLITCH_CYC)
  ) u_glitch (
    .clk_i   (clk_i),
    .arst_n_i(rst_int_n),
    .fail_i  (~async_s[BIT_PWR]),
    .fail_o  (fail_flt)
  );

  rstsup_wdog #(
    .WDOG_CYC(WDOG_CYC)
  ) u_wdog (
    .clk_i   (clk_i),
    .arst_n_i(rst_int_n),
    .hold_i  (rst_active),
    .kick_n_i(async_s[BIT_KICK]),
    .bite_o  (wd_bite)
  );

  assign req = fail_flt | ~ext_sn | wd_bite;

  rstsup_stretch #(
    .HOLD_CYC(HOLD_CYC)
  ) u_stretch (
    .clk_i   (clk_i),
    .arst_n_i(rst_int_n),
    .req_i   (req),
    .active_o(rst_active)
  );

  assign rst_o     = rst_active;
  assign rst_n_o   = ~rst_active;
  assign wr_lock_o = rst_active;

endmodule

// File: rtl/rstsup_chk.sv
module rstsup_chk #(
  parameter int unsigned HOLD_CYC = 16
) (
  input logic clk_i,
  input logic rst_int_n,
  input logic rst_o,
  input logic rst_n_o,
  input logic wr_lock_o,
  input logic ext_sn,
  input logic fail_flt,
  input logic wd_bite,
  input logic req
);

  localparam int unsigned   QW      = $clog2(HOLD_CYC + 1);
  localparam logic [QW-1:0] Q_LIMIT = QW'(HOLD_CYC);

  // Cycles of asserted reset since the last request.
  logic [QW-1:0] quiet_q;

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n)              quiet_q <= '0;
    else if (req || !rst_o)      quiet_q <= '0;
    else if (quiet_q != Q_LIMIT) quiet_q <= quiet_q + 1'b1;
  end

  p_compl_r2: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    rst_o != rst_n_o);

  p_lock_r3: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    wr_lock_o == rst_o);

  p_bite_r5: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    wd_bite |=> rst_o);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    $fell(rst_o) |-> quiet_q == Q_LIMIT);

  p_ext_r8: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    !ext_sn |=> rst_o);

  p_fail_r9: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    fail_flt |=> rst_o);

endmodule

bind rstsup_top rstsup_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk_i    (clk_i),
  .rst_int_n(rst_int_n),
  .rst_o    (rst_o),
  .rst_n_o  (rst_n_o),
  .wr_lock_o(wr_lock_o),
  .ext_sn   (ext_sn),
  .fail_flt (fail_flt),
  .wd_bite  (wd_bite),
  .req      (req)
);

// File: tb/rstsup_top_tb_top.sv
module rstsup_top_tb_top;

  localparam int G = 4;
  localparam int W = 64;
  localparam int H = 16;

  logic clk = 1'b0;
  logic rst_n, pwr_good, kick_n, ext_n;
  logic rst_o, rst_n_o, wr_lock_o;

  int n_chk = 0;
  int n_err = 0;
  int exp_q[$];
  int pulses_seen = 0;
  int kmode = 1; // 0 toggle, 1 hold high, 2 hold low

  always #10 clk = ~clk;

  rstsup_top #(
    .SYNC_STAGES(2), .GLITCH_CYC(G), .WDOG_CYC(W), .HOLD_CYC(H)
  ) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .pwr_good_i(pwr_good),
    .wdog_kick_n_i(kick_n), .ext_rst_n_i(ext_n),
    .rst_o(rst_o), .rst_n_o(rst_n_o), .wr_lock_o(wr_lock_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // Kick driver
  initial begin
    int kc = 0;
    kick_n = 1'b1;
    forever begin
      @(negedge clk);
      kc++;
      case (kmode)
        0: if (kc % 8 == 0) kick_n = ~kick_n;
        1: kick_n = 1'b1;
        default: kick_n = 1'b0;
      endcase
    end
  end

  // Monitor: per-cycle R2/R3 and scoreboard of pulse lengths (R7)
  initial begin
    bit prev = 1'b1;
    bit inpulse = 1'b0;
    int len = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        chk(rst_n_o == !rst_o, "R2 complement", rst_n_o, !rst_o);
        chk(wr_lock_o == rst_o, "R3 lockout", wr_lock_o, rst_o);
        if (rst_o && !prev) begin
          inpulse = 1'b1;
          len = 1;
        end else if (rst_o && inpulse) begin
          len++;
        end else if (!rst_o && prev && inpulse) begin
          inpulse = 1'b0;
          pulses_seen++;
          if (exp_q.size() == 0) chk(1'b0, "R7 unexpected pulse", len, 0);
          else begin
            int e;
            e = exp_q.pop_front();
            chk(len == e, "R7 pulse length", len, e);
          end
        end
        prev = rst_o;
      end
    end
  end

  task automatic ext_pulse(input int L);
    exp_q.push_back(L + H - 1);
    @(negedge clk);
    ext_n = 1'b0;
    for (int i = 1; i <= L; i++) begin
      @(negedge clk);
      if (i == 2) chk(rst_o == 1'b0, "R8 not yet", rst_o, 0);
      if (i == 3) chk(rst_o == 1'b1, "R8 start edge", rst_o, 1);
    end
    ext_n = 1'b1;
    repeat (L + H + 10) @(negedge clk);
  endtask

  task automatic pwr_dip(input int D);
    int pre;
    pre = pulses_seen;
    if (D >= G) exp_q.push_back(D + H - G);
    @(negedge clk);
    pwr_good = 1'b0;
    repeat (D) @(negedge clk);
    pwr_good = 1'b1;
    repeat (D + H + 10) @(negedge clk);
    chk(pulses_seen == pre + ((D >= G) ? 1 : 0), "R9 pulse count",
        pulses_seen - pre, (D >= G) ? 1 : 0);
  endtask

  task automatic measure_gap(output int g);
    while (rst_o) @(negedge clk);
    g = 0;
    while (!rst_o && g < 4 * W) begin
      g++;
      @(negedge clk);
    end
  endtask

  // Driver
  initial begin
    int gap;
    int pre;
    rst_n = 1'b0; pwr_good = 1'b1; ext_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rst_o == 1 && rst_n_o == 0 && wr_lock_o == 1, "R1 reset state", rst_o, 1);
    rst_n = 1'b1;
    kmode = 0;
    repeat (H + 1) @(negedge clk);
    chk(rst_o == 1'b1, "R1 still held", rst_o, 1);
    @(negedge clk);
    chk(rst_o == 1'b0, "R1 released", rst_o, 0);
    repeat (10) @(negedge clk);

    ext_pulse(5);   // R8
    ext_pulse(1);   // R8
    pwr_dip(G - 1); // R9 ignored
    pwr_dip(1);     // R9 ignored
    pwr_dip(G);     // R9
    pwr_dip(10);    // R9

    // Watchdog: steady high kick, then steady low (R5, R6, R10)
    kmode = 1;
    exp_q.push_back(H);        // external pulse
    exp_q.push_back(H);        // first bite
    @(negedge clk);
    ext_n = 1'b0;
    @(negedge clk);
    ext_n = 1'b1;
    while (!rst_o) @(negedge clk);
    measure_gap(gap);
    chk(gap == W + 1, "R5 R10 gap with kick high", gap, W + 1);
    kmode = 2;
    exp_q.push_back(H);        // repeated bite
    measure_gap(gap);
    chk(gap == W + 1, "R6 repeat gap with kick low", gap, W + 1);

    // Regular kicks keep the watchdog quiet (R4)
    kmode = 0;
    while (rst_o) @(negedge clk);
    pre = pulses_seen;
    repeat (3 * W) @(negedge clk);
    chk(pulses_seen == pre, "R4 kicks prevent reset", pulses_seen - pre, 0);
    chk(rst_o == 1'b0, "R4 output low", rst_o, 0);
    chk(exp_q.size() == 0, "R7 all pulses seen", exp_q.size(), 0);
    finish_run();
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    finish_run();
  end

endmodule